// File: doc/BRIEF.md
# Timer Output Compare Channel

This block is one output compare channel. It watches the value of an external free-running timer and drives a single output pin. The timer itself is outside the block. The block sees the timer as a count bus plus a one-cycle strobe that marks the last count of each period. After the strobe, the timer restarts at zero.

Two compare values are supplied, a primary and a secondary, together with a mode code. The block supports several modes:
- single-match modes that set, clear or toggle the pin when the timer equals the primary value;
- a dual-compare mode, in which the primary match raises the pin and the secondary match lowers it;
- a PWM mode, in which the secondary value is the duty.

In PWM mode the duty is copied into a shadow register on each period strobe. The pin is registered, so every pin change appears one clock after the cycle that causes it.

Top module: `oc_channel`

## Requirements
- R1: After reset the pin is low. Mode code 0 (off) drives the pin low from the next cycle on.
- R2: Mode code 1 (set-on-match) drives the pin high in the cycle after the timer equals the primary value. At all other times the pin holds its value.
- R3: Mode code 2 (clear-on-match) drives the pin low in the cycle after the timer equals the primary value. Before that match the pin keeps its previous value. Entering this mode while the pin is high gives no low pulse.
- R4: Mode code 3 (toggle-on-match) inverts the pin in the cycle after each primary match.
- R5: Mode code 4 (dual compare) raises the pin after a primary match and lowers it after a secondary match. When both match in the same cycle, lowering wins.
- R6: In dual compare with secondary = primary + 1, the pin is high for exactly one cycle in each timer period.
- R7: On every period strobe the secondary value is copied into the duty shadow. In mode code 5 (PWM), the pin then goes high if that value is nonzero and low if it is zero. A duty of zero therefore gives a constant low pin.
- R8: In PWM mode the pin goes low after the cycle whose timer value plus one equals the latched duty. As a result the pin is high for exactly duty cycles per period, or for the whole period when the duty exceeds the last count.
- R9: A duty change between strobes has no effect until the next strobe. A change from 0 to 1 gives a one-cycle high pulse in the very next period.
- R10: The unused mode codes 6 and 7 hold the pin at its current value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 3 | Mode code |
| cmp_pri_i | input | W | Primary compare value |
| cmp_sec_i | input | W | Secondary compare value / PWM duty |
| tmr_i | input | W | Timer count |
| tmr_wrap_i | input | 1 | Strobe on the last count of a timer period |
| pin_o | output | 1 | Compare output |

## Verification
The assertions check the following on every cycle:
- the pin follows each match under the active mode;
- the pin is held low in the off mode;
- a zero duty gives no rise at a strobe;
- the duty shadow changes only at a strobe, and then takes the secondary value.

Only the bench's scenarios can show the properties that span a whole period:
- the exact pulse width for adjacent dual-compare values;
- the per-period high count for each duty;
- the first period after a duty change from 0 to 1;
- the absence of a low pulse when clear-on-match is entered with the pin high.

The bench covers these with a cycle-accurate reference model and with per-period counts.

// File: rtl/oc_pkg.sv
package oc_pkg;
  typedef enum logic [2:0] {
    OC_OFF  = 3'd0,
    OC_SET  = 3'd1,
    OC_CLR  = 3'd2,
    OC_TGL  = 3'd3,
    OC_DUAL = 3'd4,
    OC_PWM  = 3'd5
  } oc_mode_e;
endpackage

// File: rtl/oc_match.sv
module oc_match #(
  parameter int W = 16
) (
  input  logic [W-1:0] tmr_i,
  input  logic [W-1:0] ref_i,
  output logic         hit_o
);
  assign hit_o = (tmr_i == ref_i);
endmodule

// File: rtl/oc_duty_buf.sv
module oc_duty_buf #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wrap_i,
  input  logic [W-1:0] duty_i,
  input  logic [W-1:0] tmr_i,
  output logic         duty_nz_o,
  output logic         duty_end_o
);
  localparam int WE = W + 1;

  logic [W-1:0] duty_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     duty_q <= '0;
    else if (wrap_i) duty_q <= duty_i;
  end

  assign duty_nz_o = |duty_i;
  // widened so that a duty beyond the last count never ends the pulse
  assign duty_end_o = (WE'(tmr_i) + WE'(1)) == WE'(duty_q);

  p_duty_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap_i |=> $stable(duty_q));
  p_duty_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_i |=> duty_q == $past(duty_i));
endmodule

// File: rtl/oc_pin_ctrl.sv
module oc_pin_ctrl
  import oc_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  oc_mode_e mode_i,
  input  logic     hit_pri_i,
  input  logic     hit_sec_i,
  input  logic     wrap_i,
  input  logic     duty_nz_i,
  input  logic     duty_end_i,
  output logic     pin_o
);
  logic pin_q, pin_d;

  always_comb begin
    pin_d = pin_q;
    case (mode_i)
      OC_OFF:  pin_d = 1'b0;
      OC_SET:  if (hit_pri_i) pin_d = 1'b1;
      OC_CLR:  if (hit_pri_i) pin_d = 1'b0;
      OC_TGL:  if (hit_pri_i) pin_d = ~pin_q;
      OC_DUAL: begin
        if (hit_sec_i)      pin_d = 1'b0;
        else if (hit_pri_i) pin_d = 1'b1;
      end
      OC_PWM: begin
        if (wrap_i)          pin_d = duty_nz_i;
        else if (duty_end_i) pin_d = 1'b0;
      end
      default: pin_d = pin_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_q <= 1'b0;
    else         pin_q <= pin_d;
  end

  assign pin_o = pin_q;

  p_off_low_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == OC_OFF |=> !pin_o);
  p_set_hit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == OC_SET && hit_pri_i) |=> pin_o);
  p_clr_wait_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == OC_CLR && !hit_pri_i) |=> $stable(pin_o));
  p_tgl_flip_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == OC_TGL && hit_pri_i) |=> pin_o != $past(pin_o));
  p_dual_reset_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == OC_DUAL && hit_sec_i) |=> !pin_o);
  p_pwm_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == OC_PWM && wrap_i && !duty_nz_i) |=> !pin_o);
  p_pwm_end_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == OC_PWM && !wrap_i && duty_end_i) |=> !pin_o);
endmodule

// File: rtl/oc_channel.sv
module oc_channel
  import oc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [2:0]   mode_i,
  input  logic [W-1:0] cmp_pri_i,
  input  logic [W-1:0] cmp_sec_i,
  input  logic [W-1:0] tmr_i,
  input  logic         tmr_wrap_i,
  output logic         pin_o
);
  localparam int NCMP = 2;

  logic [NCMP-1:0][W-1:0] refs;
  logic [NCMP-1:0]        hits;
  logic                   duty_nz, duty_end;

  assign refs[0] = cmp_pri_i;
  assign refs[1] = cmp_sec_i;

  for (genvar g = 0; g < NCMP; g++) begin : g_cmp
    oc_match #(.W(W)) u_match (
      .tmr_i(tmr_i),
      .ref_i(refs[g]),
      .hit_o(hits[g])
    );
  end

  oc_duty_buf #(.W(W)) u_duty (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wrap_i    (tmr_wrap_i),
    .duty_i    (cmp_sec_i),
    .tmr_i     (tmr_i),
    .duty_nz_o (duty_nz),
    .duty_end_o(duty_end)
  );

  oc_pin_ctrl u_pin (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_i    (oc_mode_e'(mode_i)),
    .hit_pri_i (hits[0]),
    .hit_sec_i (hits[1]),
    .wrap_i    (tmr_wrap_i),
    .duty_nz_i (duty_nz),
    .duty_end_i(duty_end),
    .pin_o     (pin_o)
  );
endmodule

// File: tb/oc_channel_test.sv
module oc_channel_test;
  localparam int W = 16;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [2:0]   mode_i = 3'd0;
  logic [W-1:0] cmp_pri_i = '0;
  logic [W-1:0] cmp_sec_i = '0;
  logic [W-1:0] tmr_i = '0;
  logic         tmr_wrap_i;
  logic         pin_o;

  int per = 9;
  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit exp_pin = 1'b0;
  int duty_m = 0;

  assign tmr_wrap_i = (int'(tmr_i) == per);

  always #2.5 clk_i = ~clk_i;

  oc_channel #(.W(W)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i),
    .cmp_pri_i(cmp_pri_i), .cmp_sec_i(cmp_sec_i),
    .tmr_i(tmr_i), .tmr_wrap_i(tmr_wrap_i), .pin_o(pin_o)
  );

  // reference model
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exp_pin = 1'b0;
      duty_m = 0;
    end else begin
      int t;
      bit w;
      t = int'(tmr_i);
      w = (t == per);
      case (mode_i)
        3'd0: exp_pin = 1'b0;
        3'd1: if (t == int'(cmp_pri_i)) exp_pin = 1'b1;
        3'd2: if (t == int'(cmp_pri_i)) exp_pin = 1'b0;
        3'd3: if (t == int'(cmp_pri_i)) exp_pin = !exp_pin;
        3'd4: begin
          if (t == int'(cmp_sec_i)) exp_pin = 1'b0;
          else if (t == int'(cmp_pri_i)) exp_pin = 1'b1;
        end
        3'd5: begin
          if (w) exp_pin = (cmp_sec_i != 0);
          else if (t + 1 == duty_m) exp_pin = 1'b0;
        end
        default: ;
      endcase
      if (w) duty_m = int'(cmp_sec_i);
    end
  end

  function automatic string tag_of(logic [2:0] m);
    case (m)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      3'd5: return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  // one clock: compare against the model, then advance the timer
  task automatic step();
    @(posedge clk_i);
    #1;
    cyc++;
    check(tag_of(mode_i), int'(pin_o), int'(exp_pin));
    tmr_i = tmr_wrap_i ? '0 : tmr_i + 1'b1;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  // advance to the start of a period, then count the high cycles over one period
  task automatic count_period(output int highs);
    while (tmr_i != 0) step();
    highs = 0;
    for (int i = 0; i <= per; i++) begin
      if (pin_o) highs++;
      step();
    end
  endtask

  always @(posedge clk_i) begin
    if (cyc > 100000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected <100000 cycles", cyc);
      finish_run();
    end
  end

  initial begin
    int h;
    #12;
    #1;
    check("R1", int'(pin_o), 0);
    rst_ni = 1'b1;
    run(4);

    // set-on-match
    mode_i = 3'd1; cmp_pri_i = 16'd3;
    run(25);
    check("R2", int'(pin_o), 1);

    // clear-on-match entered with the pin high: no early low
    mode_i = 3'd2; cmp_pri_i = 16'd7;
    while (tmr_i != 0) step();
    step();
    check("R3", int'(pin_o), 1);
    run(25);
    check("R3", int'(pin_o), 0);

    // toggle
    mode_i = 3'd3; cmp_pri_i = 16'd4;
    run(35);

    // off
    mode_i = 3'd1; run(12);
    mode_i = 3'd0; run(2);
    check("R1", int'(pin_o), 0);
    run(5);

    // dual, adjacent values
    mode_i = 3'd4; cmp_pri_i = 16'd2; cmp_sec_i = 16'd3;
    run(12);
    count_period(h);
    check("R6", h, 1);
    run(10);
    // dual, equal values
    cmp_pri_i = 16'd5; cmp_sec_i = 16'd5;
    run(12);
    count_period(h);
    check("R5", h, 0);
    // dual, wider gap
    cmp_pri_i = 16'd2; cmp_sec_i = 16'd6;
    run(12);
    count_period(h);
    check("R5", h, 4);

    // PWM: zero duty
    mode_i = 3'd5; cmp_sec_i = 16'd0;
    run(12);
    count_period(h);
    check("R7", h, 0);
    // change 0 -> 1 mid-period
    while (tmr_i != 16'd4) step();
    cmp_sec_i = 16'd1;
    run(2);
    check("R9", int'(pin_o), 0);
    count_period(h);
    check("R9", h, 1);
    cmp_sec_i = 16'd4;
    run(12);
    count_period(h);
    check("R8", h, 4);
    cmp_sec_i = 16'd10;
    run(12);
    count_period(h);
    check("R8", h, 10);
    per = 6; cmp_sec_i = 16'd3;
    run(20);
    count_period(h);
    check("R8", h, 3);

    // unused code holds the pin
    mode_i = 3'd6;
    run(15);
    check("R10", int'(pin_o), int'(exp_pin));
    mode_i = 3'd7;
    run(10);

    finish_run();
  end
endmodule